// File: doc/BRIEF.md
# Single-Frame Receive Staging Buffer

This block sits between the receive side of an Ethernet MAC and a DMA engine and holds at most one frame. The MAC presents frame bytes one per cycle with a start flag on the first byte and an end flag on the last. With the end byte it also supplies the 32-bit frame check value it has already worked out. An accepted frame is written into a local byte store. The block then reports a pending length equal to the frame byte count plus four, because the check bytes are handed on after the payload.

The DMA side works in chunks. When the block shows a frame pending and no chunk in progress, the DMA offers a grant of some byte count. The grant is cut down to the pending length, and the bytes go out on a valid/ready byte port. Each byte moved lowers the pending length and advances the read position. When the pending length reaches zero the store is free again. A frame that begins while the store is occupied is discarded whole, raises a sticky overrun flag and bumps a saturating lost-frame counter. A frame longer than the capacity is discarded and raises a sticky oversize flag. Either flag is cleared by a one-cycle clear pulse.

Two state machines drive the block. The fill machine has three states: FILL_IDLE waits for a start flag; FILL_STORE writes bytes; FILL_DROP discards bytes until an end flag.
- FILL_IDLE moves to FILL_STORE on a start byte while the store is free.
- FILL_IDLE moves to FILL_DROP on a start byte while the store is occupied.
- FILL_STORE moves to FILL_IDLE on the end byte, which commits the frame.
- FILL_STORE moves to FILL_DROP on a byte past capacity.
- FILL_DROP moves to FILL_IDLE on an end byte.
- A start byte that also carries the end flag goes from FILL_IDLE straight back to FILL_IDLE, either committing or dropping.
- An over-capacity byte that carries the end flag goes from FILL_STORE to FILL_IDLE.

The drain machine has three states: DRAIN_EMPTY, DRAIN_WAIT (a frame is pending and a grant is awaited) and DRAIN_CHUNK (bytes are being sent).
- DRAIN_EMPTY moves to DRAIN_WAIT when a frame is committed.
- DRAIN_WAIT moves to DRAIN_CHUNK when a grant of non-zero length is accepted.
- DRAIN_CHUNK moves to DRAIN_WAIT on the last byte of a chunk when frame bytes remain.
- DRAIN_CHUNK moves to DRAIN_EMPTY on the last byte of the frame.

Top module: `rx_frame_buffer`

## Requirements
- R1: During and right after reset, avail_len is 0, and buf_busy, grant_ready, out_valid, overrun_flag, oversize_flag and lost_count are all 0.
- R2: One cycle after the end byte of an accepted frame of N bytes (1 <= N <= BUF_BYTES), avail_len equals N+4 and buf_busy and grant_ready are 1.
- R3: A frame drains as its N bytes in arrival order, then the check value captured with its end byte, least significant byte first (bits 7:0, 15:8, 23:16, 31:24). While out_valid is high and out_ready is low, out_data and the read position stay unchanged.
- R4: A grant is taken when grant_valid and grant_ready are both high. The chunk length is the smaller of grant_len and avail_len, and a grant_len of 0 is ignored. After a chunk, avail_len has dropped by the chunk length and the next chunk continues at the following byte.
- R5: out_last is high on exactly the final byte of the frame, and chunk_last on exactly the final byte of each chunk. After the final frame byte, avail_len, buf_busy and grant_ready are 0.
- R6: A frame whose start byte arrives while buf_busy is 1 is discarded. overrun_flag becomes 1, lost_count rises by one, and the pending frame's length and content, including its check bytes, are unchanged.
- R7: A frame of more than BUF_BYTES bytes is not stored: avail_len stays 0 and oversize_flag becomes 1. A frame of exactly BUF_BYTES bytes is accepted.
- R8: A one-cycle pulse on overrun_clr or oversize_clr clears its flag. When a new event and its clear pulse fall in the same cycle, the flag stays 1.
- R9: While no frame is being received, bytes without the start flag have no effect. Each newly committed frame is read from its first byte.
- R10: lost_count stops at its all-ones value and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte present |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_data | input | 8 | Receive byte |
| rx_fcs | input | 32 | Frame check value, sampled with the end byte |
| grant_valid | input | 1 | DMA offers a chunk grant |
| grant_len | input | LEN_W | Requested chunk length in bytes |
| grant_ready | output | 1 | A grant can be taken this cycle |
| out_valid | output | 1 | Drain byte present |
| out_ready | input | 1 | DMA takes the drain byte |
| out_data | output | 8 | Drain byte |
| out_last | output | 1 | Drain byte is the last of the frame |
| chunk_last | output | 1 | Drain byte is the last of the chunk |
| avail_len | output | LEN_W | Bytes still pending, check bytes included |
| buf_busy | output | 1 | A frame occupies the store |
| overrun_flag | output | 1 | Sticky: a frame was dropped while occupied |
| overrun_clr | input | 1 | Clear pulse for overrun_flag |
| oversize_flag | output | 1 | Sticky: a frame exceeded capacity |
| oversize_clr | input | 1 | Clear pulse for oversize_flag |
| lost_count | output | CNT_W | Saturating count of frames dropped while occupied |

## Verification
The assertions assume that the MAC never raises a start flag inside a frame and that each frame ends with an end flag. They also assume that grant_len stays within LEN_W bits. The stimulus keeps to these rules: every frame is sent as one contiguous run with a start flag on the first byte and an end flag on the last, and grants are driven only when grant_ready is high. Back-pressure comes from a stall pattern on out_ready, so the hold checks on the drain port are exercised mid-chunk.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;

    localparam int CRC_BYTES = 4;

    typedef enum logic [1:0] {
        FILL_IDLE,
        FILL_STORE,
        FILL_DROP
    } fill_state_e;

    typedef enum logic [1:0] {
        DRAIN_EMPTY,
        DRAIN_WAIT,
        DRAIN_CHUNK
    } drain_state_e;

endpackage

// File: rtl/rxfb_fill.sv
module rxfb_fill
    import rxfb_pkg::*;
#(
    parameter int BUF_BYTES = 1536,
    parameter int LEN_W     = 11,
    parameter int ADDR_W    = 11,
    parameter int CNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [7:0]        rx_data,
    input  logic              buf_busy,
    input  logic              ovr_clr,
    input  logic              osz_clr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              commit,
    output logic [LEN_W-1:0]  commit_len,
    output logic              ovr_flag,
    output logic              osz_flag,
    output logic [CNT_W-1:0]  lost_cnt
);

    localparam logic [LEN_W-1:0] CAP = LEN_W'(BUF_BYTES);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    fill_state_e      state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic             drop_evt, size_evt;
    logic             start_hit, at_cap;

    assign start_hit = rx_valid && rx_sof;
    assign at_cap    = (cnt_q == CAP);
    assign wr_data   = rx_data;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FILL_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            FILL_IDLE: begin
                if (start_hit) begin
                    if (buf_busy) begin
                        state_d = rx_eof ? FILL_IDLE : FILL_DROP;
                    end else begin
                        cnt_d   = ONE;
                        state_d = rx_eof ? FILL_IDLE : FILL_STORE;
                    end
                end
            end
            FILL_STORE: begin
                if (rx_valid) begin
                    if (at_cap) begin
                        state_d = rx_eof ? FILL_IDLE : FILL_DROP;
                    end else begin
                        cnt_d = cnt_q + ONE;
                        if (rx_eof) state_d = FILL_IDLE;
                    end
                end
            end
            FILL_DROP: begin
                if (rx_valid && rx_eof) state_d = FILL_IDLE;
            end
            default: state_d = FILL_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_en      = 1'b0;
        wr_addr    = cnt_q[ADDR_W-1:0];
        commit     = 1'b0;
        commit_len = cnt_q + ONE;
        drop_evt   = 1'b0;
        size_evt   = 1'b0;
        unique case (state_q)
            FILL_IDLE: begin
                if (start_hit) begin
                    if (buf_busy) begin
                        drop_evt = 1'b1;
                    end else begin
                        wr_en      = 1'b1;
                        wr_addr    = '0;
                        commit     = rx_eof;
                        commit_len = ONE;
                    end
                end
            end
            FILL_STORE: begin
                if (rx_valid) begin
                    if (at_cap) begin
                        size_evt = 1'b1;
                    end else begin
                        wr_en  = 1'b1;
                        commit = rx_eof;
                    end
                end
            end
            FILL_DROP: ;
            default: ;
        endcase
    end

    // sticky events and lost-frame counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_flag <= 1'b0;
            osz_flag <= 1'b0;
            lost_cnt <= '0;
        end else begin
            ovr_flag <= drop_evt || (ovr_flag && !ovr_clr);
            osz_flag <= size_evt || (osz_flag && !osz_clr);
            if (drop_evt && (lost_cnt != '1)) lost_cnt <= lost_cnt + CNT_W'(1);
        end
    end

    AST_COMMIT_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !buf_busy); // R6
    AST_WRITE_IN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < BUF_BYTES)); // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clr) |=> ovr_flag); // R8
    AST_OSZ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (osz_flag && !osz_clr) |=> osz_flag); // R8
    AST_LOST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_cnt == '1) |=> (lost_cnt == '1)); // R10

endmodule

// File: rtl/rxfb_store.sv
module rxfb_store
    import rxfb_pkg::*;
#(
    parameter int BUF_BYTES = 1536,
    parameter int LEN_W     = 11,
    parameter int ADDR_W    = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              commit,
    input  logic [LEN_W-1:0]  commit_len,
    input  logic [31:0]       commit_fcs,
    input  logic [LEN_W-1:0]  rd_pos,
    output logic [7:0]        rd_byte
);

    logic [7:0]       mem [BUF_BYTES];
    logic [LEN_W-1:0] flen_q;
    logic [31:0]      fcs_q;
    logic [LEN_W-1:0] fcs_off;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flen_q <= '0;
            fcs_q  <= '0;
        end else if (commit) begin
            flen_q <= commit_len;
            fcs_q  <= commit_fcs;
        end
    end

    assign fcs_off = rd_pos - flen_q;

    always_comb begin
        if (rd_pos < flen_q) begin
            rd_byte = mem[rd_pos[ADDR_W-1:0]];
        end else begin
            case (fcs_off)
                LEN_W'(0): rd_byte = fcs_q[7:0];
                LEN_W'(1): rd_byte = fcs_q[15:8];
                LEN_W'(2): rd_byte = fcs_q[23:16];
                default:   rd_byte = fcs_q[31:24];
            endcase
        end
    end

    AST_READ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_pos) <= int'(flen_q) + CRC_BYTES)); // R3
    AST_COMMIT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (commit_len != '0 && int'(commit_len) <= BUF_BYTES)); // R7

endmodule

// File: rtl/rxfb_drain.sv
module rxfb_drain
    import rxfb_pkg::*;
#(
    parameter int BUF_BYTES = 1536,
    parameter int LEN_W     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             grant_valid,
    input  logic [LEN_W-1:0] grant_len,
    input  logic             out_ready,
    output logic             grant_ready,
    output logic             out_valid,
    output logic             out_last,
    output logic             chunk_last,
    output logic             frame_busy,
    output logic [LEN_W-1:0] rem_len,
    output logic [LEN_W-1:0] rd_pos
);

    localparam logic [LEN_W-1:0] CRC_ADD = LEN_W'(CRC_BYTES);
    localparam logic [LEN_W-1:0] ONE     = LEN_W'(1);

    drain_state_e     state_q, state_d;
    logic [LEN_W-1:0] rem_q, rem_d;
    logic [LEN_W-1:0] pos_q, pos_d;
    logic [LEN_W-1:0] chunk_q, chunk_d;
    logic [LEN_W-1:0] clipped;

    assign clipped = (grant_len > rem_q) ? rem_q : grant_len;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DRAIN_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            pos_q   <= '0;
            chunk_q <= '0;
        end else begin
            rem_q   <= rem_d;
            pos_q   <= pos_d;
            chunk_q <= chunk_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        pos_d   = pos_q;
        chunk_d = chunk_q;
        unique case (state_q)
            DRAIN_EMPTY: begin
                if (load) begin
                    rem_d   = load_len + CRC_ADD;
                    pos_d   = '0;
                    state_d = DRAIN_WAIT;
                end
            end
            DRAIN_WAIT: begin
                if (grant_valid && grant_len != '0) begin
                    chunk_d = clipped;
                    state_d = DRAIN_CHUNK;
                end
            end
            DRAIN_CHUNK: begin
                if (out_ready) begin
                    rem_d   = rem_q - ONE;
                    pos_d   = pos_q + ONE;
                    chunk_d = chunk_q - ONE;
                    if (chunk_q == ONE) state_d = (rem_q == ONE) ? DRAIN_EMPTY : DRAIN_WAIT;
                end
            end
            default: state_d = DRAIN_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        grant_ready = 1'b0;
        out_valid   = 1'b0;
        out_last    = 1'b0;
        chunk_last  = 1'b0;
        frame_busy  = 1'b1;
        unique case (state_q)
            DRAIN_EMPTY: frame_busy  = 1'b0;
            DRAIN_WAIT:  grant_ready = 1'b1;
            DRAIN_CHUNK: begin
                out_valid  = 1'b1;
                out_last   = (rem_q == ONE);
                chunk_last = (chunk_q == ONE);
            end
            default: frame_busy = 1'b0;
        endcase
    end

    assign rem_len = rem_q;
    assign rd_pos  = pos_q;

    AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rem_q) <= BUF_BYTES + CRC_BYTES)); // R2
    AST_LOAD_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (state_q == DRAIN_EMPTY)); // R6
    AST_CHUNK_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DRAIN_CHUNK) |-> (chunk_q != '0 && chunk_q <= rem_q)); // R4
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(pos_q))); // R3
    AST_EMPTY_NOTHING_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DRAIN_EMPTY) |-> (rem_q == '0)); // R5

endmodule

// File: rtl/rx_frame_buffer.sv
module rx_frame_buffer
    import rxfb_pkg::*;
#(
    parameter int BUF_BYTES = 1536,
    parameter int CNT_W     = 8,
    localparam int LEN_W    = $clog2(BUF_BYTES + CRC_BYTES + 1),
    localparam int ADDR_W   = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic [7:0]       rx_data,
    input  logic [31:0]      rx_fcs,
    input  logic             grant_valid,
    input  logic [LEN_W-1:0] grant_len,
    output logic             grant_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic             chunk_last,
    output logic [LEN_W-1:0] avail_len,
    output logic             buf_busy,
    output logic             overrun_flag,
    input  logic             overrun_clr,
    output logic             oversize_flag,
    input  logic             oversize_clr,
    output logic [CNT_W-1:0] lost_count
);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              commit;
    logic [LEN_W-1:0]  commit_len;
    logic [LEN_W-1:0]  rd_pos;

    rxfb_fill #(
        .BUF_BYTES (BUF_BYTES),
        .LEN_W     (LEN_W),
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W)
    ) fill_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_sof     (rx_sof),
        .rx_eof     (rx_eof),
        .rx_data    (rx_data),
        .buf_busy   (buf_busy),
        .ovr_clr    (overrun_clr),
        .osz_clr    (oversize_clr),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .commit     (commit),
        .commit_len (commit_len),
        .ovr_flag   (overrun_flag),
        .osz_flag   (oversize_flag),
        .lost_cnt   (lost_count)
    );

    rxfb_store #(
        .BUF_BYTES (BUF_BYTES),
        .LEN_W     (LEN_W),
        .ADDR_W    (ADDR_W)
    ) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .commit     (commit),
        .commit_len (commit_len),
        .commit_fcs (rx_fcs),
        .rd_pos     (rd_pos),
        .rd_byte    (out_data)
    );

    rxfb_drain #(
        .BUF_BYTES (BUF_BYTES),
        .LEN_W     (LEN_W)
    ) drain_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (commit),
        .load_len    (commit_len),
        .grant_valid (grant_valid),
        .grant_len   (grant_len),
        .out_ready   (out_ready),
        .grant_ready (grant_ready),
        .out_valid   (out_valid),
        .out_last    (out_last),
        .chunk_last  (chunk_last),
        .frame_busy  (buf_busy),
        .rem_len     (avail_len),
        .rd_pos      (rd_pos)
    );

endmodule

// File: tb/rx_frame_buffer_tb.sv
module rx_frame_buffer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BUF        = 1536;
    localparam int LW         = $clog2(BUF + 5);
    localparam int CW         = 8;

    typedef struct packed {
        logic [10:0] len;
        logic [7:0]  seed;
        logic [10:0] g0;
        logic [10:0] g1;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{len: 11'd1,   seed: 8'h10, g0: 11'd2,  g1: 11'd7},
        '{len: 11'd60,  seed: 8'h22, g0: 11'd0,  g1: 11'd30},
        '{len: 11'd64,  seed: 8'h33, g0: 11'd64, g1: 11'd64},
        '{len: 11'd17,  seed: 8'h44, g0: 11'd100, g1: 11'd5},
        '{len: 11'd200, seed: 8'h55, g0: 11'd1,  g1: 11'd1},
        '{len: 11'd5,   seed: 8'h66, g0: 11'd9,  g1: 11'd9}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]    rx_data = '0;
    logic [31:0]   rx_fcs = '0;
    logic          grant_valid = 1'b0;
    logic [LW-1:0] grant_len = '0;
    logic          grant_ready, out_valid, out_last, chunk_last, buf_busy;
    logic          out_ready = 1'b1;
    logic [7:0]    out_data;
    logic [LW-1:0] avail_len;
    logic          overrun_flag, oversize_flag;
    logic          overrun_clr = 1'b0, oversize_clr = 1'b0;
    logic [CW-1:0] lost_count;

    int n_chk = 0;
    int n_fail = 0;
    int exp_lost = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_frame_buffer #(.BUF_BYTES(BUF), .CNT_W(CW)) dut_i (
        .clk (clk), .rst_n (rst_n),
        .rx_valid (rx_valid), .rx_sof (rx_sof), .rx_eof (rx_eof),
        .rx_data (rx_data), .rx_fcs (rx_fcs),
        .grant_valid (grant_valid), .grant_len (grant_len), .grant_ready (grant_ready),
        .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
        .out_last (out_last), .chunk_last (chunk_last),
        .avail_len (avail_len), .buf_busy (buf_busy),
        .overrun_flag (overrun_flag), .overrun_clr (overrun_clr),
        .oversize_flag (oversize_flag), .oversize_clr (oversize_clr),
        .lost_count (lost_count)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] fcs_of(input logic [7:0] s);
        return {s ^ 8'h3C, s + 8'd7, ~s, s ^ 8'h81};
    endfunction

    function automatic logic [7:0] exp_byte(input int pos, input int len, input logic [7:0] s);
        logic [31:0] f;
        f = fcs_of(s);
        if (pos < len) return s + 8'(pos);
        return f[(pos - len) * 8 +: 8];
    endfunction

    task automatic send_frame(input int len, input logic [7:0] s);
        rx_fcs = fcs_of(s);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_eof   = (i == len - 1);
            rx_data  = s + 8'(i);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    endtask

    task automatic drop_one(input logic [7:0] s, input bit clr);
        @(negedge clk);
        rx_valid = 1'b1; rx_sof = 1'b1; rx_eof = 1'b1; rx_data = s;
        rx_fcs = fcs_of(s); overrun_clr = clr;
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; overrun_clr = 1'b0;
        if (exp_lost < 255) exp_lost++;
    endtask

    // called at a negedge with a frame pending
    task automatic drain(input int g, input int len, input logic [7:0] s, inout int pos);
        int total, rem, exp_chunk, n, guard;
        bit rdy;
        total = len + 4;
        rem = total - pos;
        exp_chunk = (g == 0) ? 0 : ((g < rem) ? g : rem);
        chk(grant_ready == 1'b1, "R4", "grant_ready before grant", int'(grant_ready), 1);
        grant_valid = 1'b1; grant_len = LW'(g);
        @(negedge clk);
        grant_valid = 1'b0; grant_len = '0;
        n = 0; guard = 0;
        while (out_valid && guard < 6000) begin
            chk(out_data == exp_byte(pos, len, s), "R3", "out_data",
                int'(out_data), int'(exp_byte(pos, len, s)));
            rdy = ((pos + guard) % 3) != 2;
            out_ready = rdy;
            if (rdy) begin
                chk(out_last == (pos == total - 1), "R5", "out_last", int'(out_last), int'(pos == total - 1));
                chk(chunk_last == (n == exp_chunk - 1), "R5", "chunk_last", int'(chunk_last), int'(n == exp_chunk - 1));
                pos++; n++;
            end
            guard++;
            @(negedge clk);
        end
        out_ready = 1'b1;
        chk(n == exp_chunk, "R4", "chunk byte count", n, exp_chunk);
        chk(int'(avail_len) == total - pos, "R4", "avail_len after chunk", int'(avail_len), total - pos);
        chk(grant_ready == (pos < total), "R4", "grant_ready after chunk", int'(grant_ready), int'(pos < total));
        chk(buf_busy == (pos < total), "R5", "buf_busy after chunk", int'(buf_busy), int'(pos < total));
    endtask

    task automatic drain_all(input int len, input logic [7:0] s);
        int pos;
        pos = 0;
        drain(2047, len, s, pos);
        chk(pos == len + 4, "R5", "bytes drained", pos, len + 4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while held in reset
        chk(avail_len == '0 && !buf_busy && !grant_ready && !out_valid, "R1", "idle outputs in reset",
            int'(avail_len), 0);
        chk(!overrun_flag && !oversize_flag && lost_count == '0, "R1", "status in reset",
            int'(lost_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(avail_len == '0 && !buf_busy && !grant_ready && !out_valid, "R1", "idle outputs after reset",
            int'(avail_len), 0);

        // table of frames and grant sizes
        for (int v = 0; v < NVEC; v++) begin
            int len, pos;
            len = int'(VECS[v].len);
            send_frame(len, VECS[v].seed);
            chk(int'(avail_len) == len + 4, "R2", "avail_len after commit", int'(avail_len), len + 4);
            chk(buf_busy && grant_ready, "R2", "busy and grant_ready", int'(grant_ready), 1);
            pos = 0;
            drain(int'(VECS[v].g0), len, VECS[v].seed, pos);
            if (pos < len + 4) drain(int'(VECS[v].g1), len, VECS[v].seed, pos);
            if (pos < len + 4) drain(2047, len, VECS[v].seed, pos);
            chk(pos == len + 4, "R5", "frame fully drained", pos, len + 4);
        end

        // R9: stray bytes without a start flag while idle
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'(i); rx_eof = (i == 4);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_eof = 1'b0;
        @(negedge clk);
        chk(avail_len == '0 && !buf_busy && !grant_ready, "R9", "stray bytes ignored", int'(avail_len), 0);
        send_frame(3, 8'hA0);
        chk(int'(avail_len) == 7, "R9", "frame after stray bytes", int'(avail_len), 7);
        drain_all(3, 8'hA0);

        // R6: frame arriving while occupied is dropped
        send_frame(10, 8'h70);
        send_frame(4, 8'h90);
        if (exp_lost < 255) exp_lost++;
        chk(overrun_flag == 1'b1, "R6", "overrun_flag", int'(overrun_flag), 1);
        chk(int'(lost_count) == exp_lost, "R6", "lost_count", int'(lost_count), exp_lost);
        chk(int'(avail_len) == 14, "R6", "pending length kept", int'(avail_len), 14);
        drain_all(10, 8'h70);
        send_frame(2, 8'hB1);
        chk(int'(avail_len) == 6, "R6", "accepted after drain", int'(avail_len), 6);
        drain_all(2, 8'hB1);

        // R8: clear pulse, then event and clear together
        @(negedge clk); overrun_clr = 1'b1;
        @(negedge clk); overrun_clr = 1'b0;
        chk(overrun_flag == 1'b0, "R8", "overrun cleared", int'(overrun_flag), 0);
        send_frame(3, 8'hC0);
        drop_one(8'hC5, 1'b1);
        chk(overrun_flag == 1'b1, "R8", "set wins over clear", int'(overrun_flag), 1);
        @(negedge clk); overrun_clr = 1'b1;
        @(negedge clk); overrun_clr = 1'b0;
        chk(overrun_flag == 1'b0, "R8", "overrun cleared again", int'(overrun_flag), 0);
        drain_all(3, 8'hC0);

        // R7: oversize frame, then exactly full frame
        send_frame(BUF + 1, 8'h01);
        chk(avail_len == '0 && !buf_busy, "R7", "oversize not stored", int'(avail_len), 0);
        chk(oversize_flag == 1'b1, "R7", "oversize_flag", int'(oversize_flag), 1);
        chk(overrun_flag == 1'b0, "R7", "overrun untouched", int'(overrun_flag), 0);
        send_frame(BUF, 8'h02);
        chk(int'(avail_len) == BUF + 4, "R7", "full-size frame accepted", int'(avail_len), BUF + 4);
        drain_all(BUF, 8'h02);
        @(negedge clk); oversize_clr = 1'b1;
        @(negedge clk); oversize_clr = 1'b0;
        chk(oversize_flag == 1'b0, "R8", "oversize cleared", int'(oversize_flag), 0);

        // R10: lost_count saturates
        send_frame(2, 8'hD0);
        for (int k = 0; k < 260; k++) drop_one(8'(k), 1'b0);
        chk(int'(lost_count) == exp_lost, "R10", "lost_count saturated", int'(lost_count), exp_lost);
        chk(int'(lost_count) == 255, "R10", "lost_count at all ones", int'(lost_count), 255);
        drain_all(2, 8'hD0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule